// File: doc/BRIEF.md
# FM Port Write Trap Controller

This block sits behind a four-byte legacy FM synthesizer I/O window and records what the host writes there. It produces no sound. Three trap registers hold what it saw: a bank code, the most recent index byte and the most recent data byte. Address bit 0 picks the index port (0) or the data port (1). Address bit 1 picks the low bank (0) or the high bank (1).

When trapping is enabled in a 4-bit configuration register, a write to a data port raises an interrupt request toward the processor. It raises NMI or SMI, depending on a configuration bit. The trap handler reads the trap registers through a separate four-byte status read port. That read also acknowledges the pending interrupt. The host reaches the FM window and the configuration register over a simple bus of address, data, and read and write strobes. A window enable gates FM writes.

Top module: `fm_trap_ctrl`

## Requirements
- R1: A write with `fm_en` and `fm_sel` high and address bit 0 = 0 loads the index register with the written byte and the bank register with 0x01 (address bit 1 = 0) or 0x02 (address bit 1 = 1), visible one cycle later.
- R2: A write with `fm_en` and `fm_sel` high and address bit 0 = 1 loads only the data register; the bank and index registers keep their values.
- R3: A data-port write while configuration bit 0 is 1 sets `smi_o` when configuration bit 2 is 1, and `nmi_o` when bit 2 is 0, one cycle after the write.
- R4: Index-port writes never change `nmi_o` or `smi_o`, and data-port writes leave them unchanged while configuration bit 0 is 0.
- R5: A pulse on `st_rd` while configuration bit 0 is 1 clears `smi_o` (bit 2 = 1) or `nmi_o` (bit 2 = 0) one cycle later; while bit 0 is 0 it has no effect.
- R6: A configuration write (`cfg_sel` and `io_wr`) keeps only data bits 3:0. A configuration read (`cfg_sel` and `io_rd`) returns those bits in the low nibble and zero in bits 7:4.
- R7: A configuration write by itself never changes `nmi_o` or `smi_o`.
- R8: A read with `fm_sel` returns 0x00 on `io_rdata`. FM writes made while `fm_en` is 0 change no trap register.
- R9: `st_rdata` returns the bank register at status offset 0, the index register at offset 1, the data register at offset 2, and 0x00 at offset 3.
- R10: If a data-port write and an `st_rd` acknowledge fall in the same cycle with trapping enabled, the interrupt line ends up set.
- R11: After reset, all trap registers, the configuration register, `nmi_o` and `smi_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_en | input | 1 | FM window enable; gates FM writes |
| fm_sel | input | 1 | Bus cycle hits the FM window |
| cfg_sel | input | 1 | Bus cycle hits the configuration register |
| io_addr | input | 2 | Byte offset within the FM window |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data for the FM window and the configuration register |
| st_rd | input | 1 | Status-window read strobe; acknowledges the interrupt |
| st_addr | input | 2 | Status-window offset |
| st_rdata | output | 8 | Status-window read data |
| nmi_o | output | 1 | Registered NMI request level |
| smi_o | output | 1 | Registered SMI request level |

## Verification
The bench builds the block with its default parameters: 8-bit data and a 4-bit configuration register with the enable at bit 0 and the target select at bit 2. These values let a short vector walk reach both banks and both interrupt targets. They also cover the acknowledge with trapping on and with trapping off, and the masking of configuration bits 7:4. Directed tests then cover the reset values and status offset 3. They also cover FM writes with the window disabled and the same-cycle data write and acknowledge.

// File: rtl/fmtrap_pkg.sv
package fmtrap_pkg;

    // FM window offset width; bit 0 = port kind, bit 1 = bank
    localparam int ADDR_W      = 2;
    localparam int PORT_BIT    = 0;
    localparam int BANK_BIT    = 1;

    // configuration bit positions
    localparam int TRAP_EN_BIT = 0;
    localparam int SMI_SEL_BIT = 2;

    // bank codes
    localparam int BANK_LO_CODE = 1;
    localparam int BANK_HI_CODE = 2;

    // status window offsets
    typedef enum logic [ADDR_W-1:0] {
        ST_BANK  = 2'd0,
        ST_INDEX = 2'd1,
        ST_DATA  = 2'd2,
        ST_NONE  = 2'd3
    } st_off_e;

    // decoded bus events for one cycle
    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic hi_bank;
        logic cfg_wr;
        logic ack;
    } ev_t;

endpackage

// File: rtl/fmtrap_decode.sv
module fmtrap_decode
    import fmtrap_pkg::*;
(
    input  logic              fm_en,
    input  logic              fm_sel,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              st_rd,
    output ev_t               ev
);

    logic fm_wr;

    always_comb begin
        fm_wr      = fm_en && fm_sel && io_wr;
        ev.idx_wr  = fm_wr && !io_addr[PORT_BIT];
        ev.dat_wr  = fm_wr &&  io_addr[PORT_BIT];
        ev.hi_bank = io_addr[BANK_BIT];
        ev.cfg_wr  = cfg_sel && io_wr;
        ev.ack     = st_rd;
    end

endmodule

// File: rtl/fmtrap_cfg.sv
module fmtrap_cfg
    import fmtrap_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ev_t              ev,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);

    logic [CFG_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (ev.cfg_wr) cfg_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/fmtrap_trapregs.sv
module fmtrap_trapregs
    import fmtrap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_t               ev,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bank_o,
    output logic [DATA_W-1:0] index_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bank;
        logic [DATA_W-1:0] index;
        logic [DATA_W-1:0] data;
    } trap_t;

    trap_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (ev.idx_wr) begin
            tr_d.bank  = ev.hi_bank ? DATA_W'(BANK_HI_CODE) : DATA_W'(BANK_LO_CODE);
            tr_d.index = wdata;
        end
        if (ev.dat_wr) begin
            tr_d.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign bank_o  = tr_q.bank;
    assign index_o = tr_q.index;
    assign data_o  = tr_q.data;

endmodule

// File: rtl/fmtrap_irq.sv
module fmtrap_irq
    import fmtrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ev_t  ev,
    input  logic trap_en,
    input  logic smi_sel,
    output logic nmi_o,
    output logic smi_o
);

    typedef struct packed {
        logic nmi;
        logic smi;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        // acknowledge first, so a same-cycle set overrides it
        if (trap_en && ev.ack) begin
            if (smi_sel) irq_d.smi = 1'b0;
            else         irq_d.nmi = 1'b0;
        end
        if (trap_en && ev.dat_wr) begin
            if (smi_sel) irq_d.smi = 1'b1;
            else         irq_d.nmi = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign nmi_o = irq_q.nmi;
    assign smi_o = irq_q.smi;

endmodule

// File: rtl/fm_trap_ctrl.sv
module fm_trap_ctrl
    import fmtrap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fm_en,
    input  logic              fm_sel,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              st_rd,
    input  logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_rdata,
    output logic              nmi_o,
    output logic              smi_o
);

    ev_t               ev;
    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] bank_q;
    logic [DATA_W-1:0] index_q;
    logic [DATA_W-1:0] data_q;

    fmtrap_decode u_decode (
        .fm_en   (fm_en),
        .fm_sel  (fm_sel),
        .cfg_sel (cfg_sel),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .st_rd   (st_rd),
        .ev      (ev)
    );

    fmtrap_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .wdata (io_wdata[CFG_W-1:0]),
        .cfg_q (cfg_q)
    );

    fmtrap_trapregs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wdata   (io_wdata),
        .bank_o  (bank_q),
        .index_o (index_q),
        .data_o  (data_q)
    );

    fmtrap_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .trap_en (cfg_q[TRAP_EN_BIT]),
        .smi_sel (cfg_q[SMI_SEL_BIT]),
        .nmi_o   (nmi_o),
        .smi_o   (smi_o)
    );

    // host bus read: configuration register or the trap-only FM window
    always_comb begin
        io_rdata = '0;
        if (io_rd && cfg_sel)     io_rdata = DATA_W'(cfg_q);
        else if (io_rd && fm_sel) io_rdata = '0;
    end

    // status window read mux
    always_comb begin
        unique case (st_off_e'(st_addr))
            ST_BANK:  st_rdata = bank_q;
            ST_INDEX: st_rdata = index_q;
            ST_DATA:  st_rdata = data_q;
            default:  st_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fmtrap_chk.sv
module fmtrap_chk #(
    parameter int DATA_W = 8,
    parameter int CFG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fm_en,
    input logic              fm_sel,
    input logic              cfg_sel,
    input logic [1:0]        io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic              st_rd,
    input logic [DATA_W-1:0] io_rdata,
    input logic              nmi_o,
    input logic              smi_o,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [DATA_W-1:0] bank_q
);

    logic idx_w, dat_w;
    assign idx_w = fm_en && fm_sel && io_wr && !io_addr[0];
    assign dat_w = fm_en && fm_sel && io_wr &&  io_addr[0];

    assert_bank_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_w |=> bank_q == ($past(io_addr[1]) ? DATA_W'(2) : DATA_W'(1)));

    assert_smi_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_w && cfg_q[0] && cfg_q[2] |=> smi_o);

    assert_nmi_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_w && cfg_q[0] && !cfg_q[2] |=> nmi_o);

    assert_index_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_w && !st_rd && !cfg_sel |=> $stable(nmi_o) && $stable(smi_o));

    assert_nmi_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && cfg_q[0] && !cfg_q[2] && !dat_w |=> !nmi_o);

    assert_smi_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && cfg_q[0] && cfg_q[2] && !dat_w |=> !smi_o);

    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel && io_wr && !dat_w && !st_rd |=> $stable(nmi_o) && $stable(smi_o));

    assert_fm_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && fm_sel && !cfg_sel |-> io_rdata == '0);

endmodule

bind fm_trap_ctrl fmtrap_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fm_en    (fm_en),
    .fm_sel   (fm_sel),
    .cfg_sel  (cfg_sel),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .st_rd    (st_rd),
    .io_rdata (io_rdata),
    .nmi_o    (nmi_o),
    .smi_o    (smi_o),
    .cfg_q    (cfg_q),
    .bank_q   (bank_q)
);

// File: tb/tb_fm_trap_ctrl.sv
`timescale 1ns/1ps
module tb_fm_trap_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fm_en = 1'b1, fm_sel = 1'b0, cfg_sel = 1'b0;
    logic [1:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic       st_rd = 1'b0;
    logic [1:0] st_addr = '0;
    logic [7:0] st_rdata;
    logic       nmi_o, smi_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    fm_trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fm_en(fm_en), .fm_sel(fm_sel), .cfg_sel(cfg_sel),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata), .st_rd(st_rd), .st_addr(st_addr), .st_rdata(st_rdata),
        .nmi_o(nmi_o), .smi_o(smi_o)
    );

    // {kind, addr, wdata, exp bank, exp index, exp data, exp nmi, exp smi}
    // kind: 0 = FM write, 1 = config write, 2 = status read (acknowledge)
    localparam int NV = 13;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {2'd0, 2'd0, 8'h20, 8'h01, 8'h20, 8'h00, 1'b0, 1'b0},
        {2'd0, 2'd1, 8'h55, 8'h01, 8'h20, 8'h55, 1'b0, 1'b0},
        {2'd0, 2'd2, 8'h05, 8'h02, 8'h05, 8'h55, 1'b0, 1'b0},
        {2'd1, 2'd0, 8'hF1, 8'h02, 8'h05, 8'h55, 1'b0, 1'b0},
        {2'd0, 2'd3, 8'hA7, 8'h02, 8'h05, 8'hA7, 1'b1, 1'b0},
        {2'd0, 2'd0, 8'h40, 8'h01, 8'h40, 8'hA7, 1'b1, 1'b0},
        {2'd2, 2'd0, 8'h00, 8'h01, 8'h40, 8'hA7, 1'b0, 1'b0},
        {2'd1, 2'd0, 8'h05, 8'h01, 8'h40, 8'hA7, 1'b0, 1'b0},
        {2'd0, 2'd1, 8'h3C, 8'h01, 8'h40, 8'h3C, 1'b0, 1'b1},
        {2'd1, 2'd0, 8'h00, 8'h01, 8'h40, 8'h3C, 1'b0, 1'b1},
        {2'd2, 2'd1, 8'h00, 8'h01, 8'h40, 8'h3C, 1'b0, 1'b1},
        {2'd1, 2'd0, 8'h05, 8'h01, 8'h40, 8'h3C, 1'b0, 1'b1},
        {2'd2, 2'd2, 8'h00, 8'h01, 8'h40, 8'h3C, 1'b0, 1'b0}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] off, output logic [7:0] val);
        st_addr = off;
        #1;
        val = st_rdata;
    endtask

    // one bus operation, held for one clock edge; returns at the next falling edge
    task automatic op(input logic [1:0] kind, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        st_addr  = a;
        fm_sel   = (kind == 2'd0);
        cfg_sel  = (kind == 2'd1);
        io_wr    = (kind != 2'd2);
        st_rd    = (kind == 2'd2);
        @(negedge clk);
        fm_sel = 1'b0; cfg_sel = 1'b0; io_wr = 1'b0; st_rd = 1'b0;
    endtask

    task automatic read_cfg(output logic [7:0] val);
        cfg_sel = 1'b1; io_rd = 1'b1;
        #1;
        val = io_rdata;
        cfg_sel = 1'b0; io_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        for (int i = 0; i < 3; i++) begin
            peek(i[1:0], v); check(v, 8'h00, "R11 trap reg after reset");
        end
        check({7'd0, nmi_o}, 8'h00, "R11 nmi after reset");
        check({7'd0, smi_o}, 8'h00, "R11 smi after reset");
        read_cfg(v); check(v, 8'h00, "R11 cfg after reset");

        // vector walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            logic [37:0] e;
            e = VEC[i];
            op(e[37:36], e[35:34], e[33:26]);
            peek(2'd0, v); check(v, e[25:18], "R1 bank");
            peek(2'd1, v); check(v, e[17:10], "R1 index");
            peek(2'd2, v); check(v, e[9:2],   "R2 data");
            check({7'd0, nmi_o}, {7'd0, e[1]}, "R3 R4 R5 R7 nmi");
            check({7'd0, smi_o}, {7'd0, e[0]}, "R3 R4 R5 R7 smi");
        end

        // R6: upper config bits masked
        op(2'd1, 2'd0, 8'hF1);
        read_cfg(v); check(v, 8'h01, "R6 cfg readback");
        op(2'd1, 2'd0, 8'hAE);
        read_cfg(v); check(v, 8'h0E, "R6 cfg readback");

        // R8: FM reads return zero
        for (int a = 0; a < 4; a++) begin
            fm_sel = 1'b1; io_rd = 1'b1; io_addr = a[1:0];
            #1;
            check(io_rdata, 8'h00, "R8 fm read");
            fm_sel = 1'b0; io_rd = 1'b0;
        end

        // R8: writes ignored with window disabled
        fm_en = 1'b0;
        op(2'd0, 2'd1, 8'h99);
        op(2'd0, 2'd2, 8'h77);
        fm_en = 1'b1;
        peek(2'd2, v); check(v, 8'h3C, "R8 data kept while disabled");
        peek(2'd1, v); check(v, 8'h40, "R8 index kept while disabled");

        // R9: status offset 3
        peek(2'd3, v); check(v, 8'h00, "R9 offset 3");

        // R4: data write with trapping off raises nothing
        op(2'd1, 2'd0, 8'h04);
        op(2'd0, 2'd3, 8'h12);
        check({6'd0, nmi_o, smi_o}, 8'h00, "R4 trap disabled");

        // R10: same-cycle data write and acknowledge, NMI target
        op(2'd1, 2'd0, 8'h01);
        @(negedge clk);
        fm_sel = 1'b1; io_wr = 1'b1; io_addr = 2'd1; io_wdata = 8'h66; st_rd = 1'b1;
        @(negedge clk);
        fm_sel = 1'b0; io_wr = 1'b0; st_rd = 1'b0;
        check({7'd0, nmi_o}, 8'h01, "R10 set wins");
        peek(2'd2, v); check(v, 8'h66, "R2 data on simultaneous cycle");

        // R5: plain acknowledge then clears
        op(2'd2, 2'd0, 8'h00);
        check({7'd0, nmi_o}, 8'h00, "R5 nmi cleared");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule